// File: doc/BRIEF.md
# Narrow-to-Wide Registered Bus Exchanger

This block joins a narrow A bus to a wide B bus made of two equal halves, a low half and a high half. In the A-to-B direction, two consecutive A words are gathered and presented together as one wide word. The low half passes through two register stages, and the high half passes through one. A single load strobe on the pair stage therefore moves the older word onto the low half in the same edge that captures the newer word into the high half. In the B-to-A direction, each half has its own capture register. A select line picks which captured half drives A.

Bidirectional pins are modelled as separate input, output and drive-enable signals. The drive requests for A and B are active low and are registered, so a change of bus direction takes effect only on a clock edge. A disabled port still presents its register contents on its data outputs.

All registers capture on the rising clock edge. Each register loads only while its own active-low load input is low. A synchronous active-low reset clears every data register and turns both drives off.

Top module: `bus_pair_xchg`

## Requirements
- R1: While `rst_n` is low at a rising edge, every data output is zero after that edge, and `a_oe` and `b_oe` are 0 (not driving).
- R2: The first low-half stage captures `a_in` at an edge where `ld_first_n` is 0 and holds its value when `ld_first_n` is 1. It is observed on `lo_out` after the next pair load.
- R3: At an edge where `ld_pair_n` is 0, `lo_out` takes the value held in the first stage before that edge, and `hi_out` takes `a_in`. Two words loaded on successive edges therefore appear together on `lo_out`/`hi_out`.
- R4: While `ld_pair_n` is 1, `lo_out` and `hi_out` keep their values whatever `a_in` and `ld_first_n` do.
- R5: The low-half return register captures `lo_in` at an edge where `cap_lo_n` is 0 and holds its value otherwise.
- R6: The high-half return register captures `hi_in` at an edge where `cap_hi_n` is 0 and holds its value otherwise.
- R7: `a_out` shows the low-half return register when `pick_hi` is 0 and the high-half return register when `pick_hi` is 1. The select is combinational, so `a_out` follows `pick_hi` within the same cycle.
- R8: `a_oe` equals the inverse of `a_drv_n` as sampled at the previous rising edge, and `b_oe` equals the inverse of `b_drv_n` in the same way. A pulse on a request that starts and ends between edges has no effect.
- R9: When a drive is off, the matching data outputs still carry the register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | W | Narrow bus input word |
| ld_first_n | input | 1 | Load for the first low-half stage, active low |
| ld_pair_n | input | 1 | Load for the second low-half stage and the high-half register, active low |
| lo_out | output | W | Low half of the wide output word |
| hi_out | output | W | High half of the wide output word |
| b_oe | output | 1 | Wide-bus drive enable, 1 = driving |
| b_drv_n | input | 1 | Wide-bus drive request, active low, registered |
| lo_in | input | W | Low half of the wide input word |
| hi_in | input | W | High half of the wide input word |
| cap_lo_n | input | 1 | Load for the low-half return register, active low |
| cap_hi_n | input | 1 | Load for the high-half return register, active low |
| pick_hi | input | 1 | 0 selects the low-half return register, 1 the high-half one |
| a_out | output | W | Narrow bus output word |
| a_oe | output | 1 | Narrow-bus drive enable, 1 = driving |
| a_drv_n | input | 1 | Narrow-bus drive request, active low, registered |

## Verification
A first stage that loads at the wrong time does not show up at once. It appears on `lo_out` only at the next pair load, one or more cycles later. This is why the checks pair every first-stage load with a following pair load. A wrong high-half or return register shows up on the edge right after the load, on `hi_out` or `a_out`, depending on `pick_hi`. A drive enable that is not registered shows as `a_oe` or `b_oe` changing between edges or one cycle early.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
  typedef enum logic {HALF_LO = 1'b0, HALF_HI = 1'b1} half_e;

  // active-low load strobe decoded into a capture decision
  function automatic logic load_now(input logic en_n);
    return (en_n == 1'b0);
  endfunction

  // drive enable seen at the port from a registered active-low request
  function automatic logic drive_on(input logic req_q_n);
    return (req_q_n == 1'b0);
  endfunction
endpackage

// File: rtl/xchg_pack.sv
module xchg_pack #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  input  logic         first_en_n,
  input  logic         pair_en_n,
  output logic [W-1:0] lo_q,
  output logic [W-1:0] hi_q
);
  logic [W-1:0] stage_q;
  logic         first_fire;
  logic         pair_fire;

  assign first_fire = xchg_pkg::load_now(first_en_n);
  assign pair_fire  = xchg_pkg::load_now(pair_en_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      if (first_fire) stage_q <= d;
      if (pair_fire) begin
        lo_q <= stage_q;
        hi_q <= d;
      end
    end
  end

  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    first_en_n |=> $stable(stage_q)); // R2
  AST_PAIR_LO: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_en_n |=> lo_q == $past(stage_q)); // R3
  AST_PAIR_HI: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_en_n |=> hi_q == $past(d)); // R3
  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pair_en_n |=> ($stable(lo_q) && $stable(hi_q))); // R4
endmodule

// File: rtl/xchg_return.sv
module xchg_return #(
  parameter int W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    lo_d,
  input  logic [W-1:0]    hi_d,
  input  logic            lo_en_n,
  input  logic            hi_en_n,
  input  xchg_pkg::half_e pick,
  output logic [W-1:0]    q
);
  logic [W-1:0] lo_r;
  logic [W-1:0] hi_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_r <= '0;
      hi_r <= '0;
    end else begin
      if (xchg_pkg::load_now(lo_en_n)) lo_r <= lo_d;
      if (xchg_pkg::load_now(hi_en_n)) hi_r <= hi_d;
    end
  end

  always_comb begin
    case (pick)
      xchg_pkg::HALF_HI: q = hi_r;
      default:           q = lo_r;
    endcase
  end

  AST_LO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_en_n |=> lo_r == $past(lo_d)); // R5
  AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    lo_en_n |=> $stable(lo_r)); // R5
  AST_HI_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_en_n |=> hi_r == $past(hi_d)); // R6
  AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hi_en_n |=> $stable(hi_r)); // R6
endmodule

// File: rtl/xchg_dir.sv
module xchg_dir (
  input  logic clk,
  input  logic rst_n,
  input  logic a_req_n,
  input  logic b_req_n,
  output logic a_oe,
  output logic b_oe
);
  logic a_req_q_n;
  logic b_req_q_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_req_q_n <= 1'b1;
      b_req_q_n <= 1'b1;
    end else begin
      a_req_q_n <= a_req_n;
      b_req_q_n <= b_req_n;
    end
  end

  assign a_oe = xchg_pkg::drive_on(a_req_q_n);
  assign b_oe = xchg_pkg::drive_on(b_req_q_n);

  AST_RESET_OFF: assert property (@(posedge clk)
    !rst_n |=> (!a_oe && !b_oe)); // R1
  AST_A_DIR_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> a_oe == !$past(a_req_n)); // R8
  AST_B_DIR_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> b_oe == !$past(b_req_n)); // R8
endmodule

// File: rtl/bus_pair_xchg.sv
module bus_pair_xchg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic         ld_first_n,
  input  logic         ld_pair_n,
  output logic [W-1:0] lo_out,
  output logic [W-1:0] hi_out,
  output logic         b_oe,
  input  logic         b_drv_n,
  input  logic [W-1:0] lo_in,
  input  logic [W-1:0] hi_in,
  input  logic         cap_lo_n,
  input  logic         cap_hi_n,
  input  logic         pick_hi,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic         a_drv_n
);
  xchg_pkg::half_e pick;
  assign pick = xchg_pkg::half_e'(pick_hi);

  xchg_pack #(.W(W)) u_pack (
    .clk(clk), .rst_n(rst_n), .d(a_in),
    .first_en_n(ld_first_n), .pair_en_n(ld_pair_n),
    .lo_q(lo_out), .hi_q(hi_out)
  );

  xchg_return #(.W(W)) u_ret (
    .clk(clk), .rst_n(rst_n), .lo_d(lo_in), .hi_d(hi_in),
    .lo_en_n(cap_lo_n), .hi_en_n(cap_hi_n), .pick(pick), .q(a_out)
  );

  xchg_dir u_dir (
    .clk(clk), .rst_n(rst_n), .a_req_n(a_drv_n), .b_req_n(b_drv_n),
    .a_oe(a_oe), .b_oe(b_oe)
  );

  AST_CLEAR_LO: assert property (@(posedge clk)
    !rst_n |=> (lo_out == '0 && hi_out == '0)); // R1
endmodule

// File: tb/sim_bus_pair_xchg.sv
module sim_bus_pair_xchg;
  localparam int W = 12;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, ld_first_n, ld_pair_n, b_drv_n, cap_lo_n, cap_hi_n, pick_hi, a_drv_n;
  logic [W-1:0] a_in, lo_in, hi_in, lo_out, hi_out, a_out;
  logic a_oe, b_oe;

  bus_pair_xchg #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .ld_first_n(ld_first_n), .ld_pair_n(ld_pair_n),
    .lo_out(lo_out), .hi_out(hi_out), .b_oe(b_oe), .b_drv_n(b_drv_n),
    .lo_in(lo_in), .hi_in(hi_in), .cap_lo_n(cap_lo_n), .cap_hi_n(cap_hi_n),
    .pick_hi(pick_hi), .a_out(a_out), .a_oe(a_oe), .a_drv_n(a_drv_n)
  );

  typedef struct {
    logic [W-1:0] lo, hi, a;
    logic aoe, boe;
    string tag;
  } exp_t;
  exp_t sb[$];

  int total = 0, bad = 0;
  bit done = 0;

  // bench model, written from the requirements
  logic [W-1:0] m_stage, m_lo, m_hi, m_rlo, m_rhi;
  logic m_aoe, m_boe;

  task automatic step(input logic rst, input logic [W-1:0] a, input logic f_n, input logic p_n,
                      input logic [W-1:0] li, input logic [W-1:0] hii, input logic cl_n,
                      input logic ch_n, input logic sel, input logic ad_n, input logic bd_n,
                      input string tag);
    exp_t e;
    @(negedge clk);
    rst_n = rst; a_in = a; ld_first_n = f_n; ld_pair_n = p_n; lo_in = li; hi_in = hii;
    cap_lo_n = cl_n; cap_hi_n = ch_n; pick_hi = sel; a_drv_n = ad_n; b_drv_n = bd_n;
    if (!rst) begin
      m_stage = '0; m_lo = '0; m_hi = '0; m_rlo = '0; m_rhi = '0; m_aoe = 0; m_boe = 0;
    end else begin
      if (!p_n) begin m_lo = m_stage; m_hi = a; end
      if (!f_n) m_stage = a;
      if (!cl_n) m_rlo = li;
      if (!ch_n) m_rhi = hii;
      m_aoe = !ad_n; m_boe = !bd_n;
    end
    e.lo = m_lo; e.hi = m_hi; e.a = sel ? m_rhi : m_rlo;
    e.aoe = m_aoe; e.boe = m_boe; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: one comparison per edge after the outputs settle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        total++;
        if (lo_out !== e.lo || hi_out !== e.hi || a_out !== e.a || a_oe !== e.aoe || b_oe !== e.boe) begin
          bad++;
          $display("FAIL %s: got lo=%h hi=%h a=%h aoe=%b boe=%b exp lo=%h hi=%h a=%h aoe=%b boe=%b",
                   e.tag, lo_out, hi_out, a_out, a_oe, b_oe, e.lo, e.hi, e.a, e.aoe, e.boe);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #100000;
    bad++;
    $display("FAIL watchdog: got hung run exp completion");
    finish_run();
  end

  initial begin
    // R1: reset with every load strobe active and drives requested
    step(0, 12'hABC, 0, 0, 12'h123, 12'h456, 0, 0, 0, 0, 0, "R1");
    step(0, 12'hDEF, 0, 0, 12'h321, 12'h654, 0, 0, 1, 0, 0, "R1");
    // R2/R3: first word, then second word with pair load -> wide word 222:111
    step(1, 12'h111, 0, 1, 0, 0, 1, 1, 0, 1, 1, "R2");
    step(1, 12'h222, 1, 0, 0, 0, 1, 1, 0, 1, 1, "R3");
    // R4: hold of the wide word while the narrow bus keeps changing
    step(1, 12'h333, 0, 1, 0, 0, 1, 1, 0, 1, 1, "R4");
    step(1, 12'h444, 1, 1, 0, 0, 1, 1, 0, 1, 1, "R4");
    // R2: stage held since 333 (ld_first_n high above), pair now -> 555:333
    step(1, 12'h555, 1, 0, 0, 0, 1, 1, 0, 1, 1, "R2");
    // R3: streaming with both strobes low each edge
    for (int i = 0; i < 4; i++)
      step(1, 12'(12'h600 + i), 0, 0, 0, 0, 1, 1, 0, 1, 1, "R3");
    // R5/R6: capture each half separately, then hold
    step(1, 0, 1, 1, 12'hA5A, 12'h5A5, 0, 1, 0, 1, 1, "R5");
    step(1, 0, 1, 1, 12'hFFF, 12'hC3C, 1, 0, 1, 1, 1, "R6");
    step(1, 0, 1, 1, 12'h000, 12'h000, 1, 1, 0, 1, 1, "R5");
    step(1, 0, 1, 1, 12'h111, 12'h111, 1, 1, 1, 1, 1, "R6");
    // R7: select toggles every cycle with returns held
    for (int i = 0; i < 4; i++)
      step(1, 0, 1, 1, 0, 0, 1, 1, i[0], 1, 1, "R7");
    // R7: same-cycle response to select
    @(negedge clk);
    #0.5;
    pick_hi = 1'b0; #0.5; total++;
    if (a_out !== 12'hA5A) begin bad++; $display("FAIL R7: got a=%h exp a=%h", a_out, 12'hA5A); end
    pick_hi = 1'b1; #0.5; total++;
    if (a_out !== 12'hC3C) begin bad++; $display("FAIL R7: got a=%h exp a=%h", a_out, 12'hC3C); end
    // R8: enable A drive, then B drive, then release both
    step(1, 0, 1, 1, 0, 0, 1, 1, 1, 0, 1, "R8");
    step(1, 0, 1, 1, 0, 0, 1, 1, 1, 0, 0, "R8");
    step(1, 0, 1, 1, 0, 0, 1, 1, 1, 1, 1, "R8");
    // R8: short request pulses between edges have no effect
    @(posedge clk);
    #1.2;
    a_drv_n = 1'b0; b_drv_n = 1'b0; #0.5; total++;
    if (a_oe !== 1'b0 || b_oe !== 1'b0) begin
      bad++; $display("FAIL R8: got aoe=%b boe=%b exp aoe=0 boe=0", a_oe, b_oe);
    end
    a_drv_n = 1'b1; b_drv_n = 1'b1;
    step(1, 0, 1, 1, 0, 0, 1, 1, 1, 1, 1, "R8");
    // R9: data visible with drives off, new wide word 777:666
    step(1, 12'h666, 0, 1, 12'h0F0, 0, 0, 1, 0, 1, 1, "R9");
    step(1, 12'h777, 1, 0, 0, 0, 1, 1, 0, 1, 1, "R9");
    // R1: reset again from a loaded state with drives on
    step(1, 0, 1, 1, 0, 0, 1, 1, 0, 0, 0, "R8");
    step(0, 12'h888, 0, 0, 12'h999, 12'h999, 0, 0, 1, 0, 0, "R1");
    step(1, 0, 1, 1, 0, 0, 1, 1, 0, 1, 1, "R1");
    @(posedge clk); #2;
    finish_run();
  end
endmodule